// File: doc/BRIEF.md
# Dual-Scale Programmable Watchdog Timer with Frequency-Code Select

This block is a countdown watchdog controlled through a small register bus: a two-bit address, a write strobe, eight bits of write data and combinational read data. A control register holds a five-bit timeout, a one-bit scale select and an override bit. The scale select picks a short or a long time unit. Each unit is a parameterised number of pulses on a slow `base_tick` input. Every write to the control register reloads the countdown and restarts the unit prescaler, so software uses that write as the service operation. When the last unit runs out, a sticky expiry flag is set and the countdown stays at zero.

The override bit in the same register chooses where the active five-bit frequency code comes from. When it is clear, the code is the strap pin value captured once after reset. When it is set, the code is a software-written select register. The captured strap value can be read back but never written.

Top module: `wdt_fsel_top`

Register map (address: content). Every bit not listed is reserved, reads 0 and ignores writes.
- 0, control: bit 6 override, bits 5:1 timeout in units, bit 0 scale select (0 short, 1 long). Reset value 0x3E.
- 1, status: bit 0 expiry flag. Writing 1 to bit 0 clears it.
- 2, software select: bits 4:0 frequency code. Reset value 0x00.
- 3, strap readback (read-only): bits 4:0 hold the captured strap value.

## Requirements
- R1: After reset, address 0 reads 0x3E, address 1 reads 0x00, address 2 reads 0x00, and `wd_expired` is 0.
- R2: A timeout field of 0 gives 32 units. A value n from 1 to 31 gives n units.
- R3: One unit is TICKS_SHORT base ticks when control bit 0 is 0 and TICKS_LONG base ticks when it is 1. After a control write, the flag rises on the clock edge that accepts the (units × ticks-per-unit)-th base tick that follows the write edge.
- R4: When the countdown reaches zero, `wd_expired` and status bit 0 become 1. The countdown then stays at zero, so a flag cleared after expiry stays clear until a new control write.
- R5: The expiry flag is sticky. A status write with bit 0 equal to 0 leaves it set. A status write with bit 0 equal to 1 clears it on that write's clock edge.
- R6: Any write to address 0 reloads the countdown with the new field value and restarts the partial unit, which postpones expiry.
- R7: `freq_code` equals the captured strap value while control bit 6 is 0, and equals address 2 bits 4:0 while control bit 6 is 1.
- R8: `strap_fs` is captured on the first clock edge after reset is released. Later pin changes and writes to address 3 do not alter `freq_code` or the address 3 readback.
- R9: Reserved bits read 0 even after writing all ones: address 0 reads 0x7F and address 2 reads 0x1F after writing 0xFF to each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle pulse that advances the prescaler |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| strap_fs | input | 5 | Strap pins for the frequency code |
| freq_code | output | 5 | Active frequency code |
| wd_expired | output | 1 | Sticky expiry flag |

## Verification
The assertions assume that the scale select changes only through a control write, which also restarts the prescaler. Under that assumption the prescaler count is always below the limit of the current scale. They also assume the write strobe is a clean single-cycle pulse, synchronous to the clock. The bench drives every input at the falling edge, issues each write for exactly one cycle, and holds `base_tick` high so that each cycle is one tick. Tick timing then stays within those assumptions, and expiry cycles can be counted exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned TMO_W   = 5;
  localparam int unsigned FS_W    = 5;
  localparam int unsigned UNITS_W = TMO_W + 1;
  localparam logic [TMO_W-1:0] TMO_RST = '1;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_STAT  = 2'd1,
    A_SEL   = 2'd2,
    A_STRAP = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             rsvd;
    logic             ovr;
    logic [TMO_W-1:0] tmo;
    logic             psel;
  } ctrl_t;

  function automatic logic [UNITS_W-1:0] units_of(input logic [TMO_W-1:0] f);
    units_of = (f == '0) ? UNITS_W'(1 << TMO_W) : UNITS_W'(f);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICKS_SHORT = 3,
  parameter int unsigned TICKS_LONG  = 50,
  localparam int unsigned TMAX = (TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT,
  localparam int unsigned PW   = (TMAX > 2) ? $clog2(TMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          long_sel,
  output logic          unit_done,
  output logic [PW-1:0] cnt_o
);
  logic [PW-1:0] cnt_q, cnt_d, lim_m1;

  always_comb begin
    lim_m1    = long_sel ? PW'(TICKS_LONG - 1) : PW'(TICKS_SHORT - 1);
    cnt_d     = cnt_q;
    unit_done = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= lim_m1) begin
        cnt_d     = '0;
        unit_done = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TMO_W-1:0]   load_val,
  input  logic               unit_done,
  output logic [UNITS_W-1:0] units_o,
  output logic               expire_o
);
  logic [UNITS_W-1:0] units_q, units_d;
  logic               dec_en;

  always_comb begin
    dec_en   = unit_done && (units_q != '0);
    units_d  = units_q;
    expire_o = 1'b0;
    if (load) begin
      units_d = units_of(load_val);
    end else if (dec_en) begin
      units_d  = units_q - 1'b1;
      expire_o = (units_q == UNITS_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) units_q <= units_of(TMO_RST);
    else        units_q <= units_d;
  end

  assign units_o = units_q;
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [FS_W-1:0] strap_fs,
  input  logic            expire,
  output ctrl_t           ctrl_o,
  output logic            ctrl_wr_o,
  output logic            flag_o,
  output logic [FS_W-1:0] strap_lat_o,
  output logic            strap_done_o,
  output logic [FS_W-1:0] freq_code
);
  ctrl_t           ctrl_q, ctrl_d;
  logic [FS_W-1:0] sel_q, sel_d;
  logic [FS_W-1:0] lat_q, lat_d;
  logic            flag_q, flag_d;
  logic            done_q, done_d;
  logic            wr_ctrl, wr_stat, wr_sel;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_sel  = reg_wr && (reg_addr == A_SEL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d      = ctrl_t'(reg_wdata);
      ctrl_d.rsvd = 1'b0;
    end
    sel_d  = wr_sel ? reg_wdata[FS_W-1:0] : sel_q;
    done_d = 1'b1;
    lat_d  = done_q ? lat_q : strap_fs;
    flag_d = flag_q;
    if (expire)                     flag_d = 1'b1;
    else if (wr_stat && reg_wdata[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{rsvd: 1'b0, ovr: 1'b0, tmo: TMO_RST, psel: 1'b0};
      sel_q  <= '0;
      lat_q  <= '0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
      lat_q  <= lat_d;
      flag_q <= flag_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {7'd0, flag_q};
      A_SEL:   reg_rdata = {{(8-FS_W){1'b0}}, sel_q};
      default: reg_rdata = {{(8-FS_W){1'b0}}, lat_q};
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign ctrl_wr_o    = wr_ctrl;
  assign flag_o       = flag_q;
  assign strap_lat_o  = lat_q;
  assign strap_done_o = done_q;
  assign freq_code    = ctrl_q.ovr ? sel_q : lat_q;
endmodule

// File: rtl/wdt_fsel_top.sv
module wdt_fsel_top
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_SHORT = 3,
  parameter int unsigned TICKS_LONG  = 50,
  localparam int unsigned TMAX = (TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT,
  localparam int unsigned PW   = (TMAX > 2) ? $clog2(TMAX) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [4:0] strap_fs,
  output logic [4:0] freq_code,
  output logic       wd_expired
);
  ctrl_t              ctrl;
  logic               ctrl_wr, unit_done, expire;
  logic [PW-1:0]      presc_cnt;
  logic [UNITS_W-1:0] units_q;
  logic [FS_W-1:0]    strap_lat;
  logic               strap_done;

  wdt_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strap_fs(strap_fs),
    .expire(expire), .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr), .flag_o(wd_expired),
    .strap_lat_o(strap_lat), .strap_done_o(strap_done), .freq_code(freq_code)
  );

  wdt_prescaler #(.TICKS_SHORT(TICKS_SHORT), .TICKS_LONG(TICKS_LONG)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .restart(ctrl_wr),
    .long_sel(ctrl.psel), .unit_done(unit_done), .cnt_o(presc_cnt)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ctrl_wr), .load_val(reg_wdata[5:1]),
    .unit_done(unit_done), .units_o(units_q), .expire_o(expire)
  );
endmodule

// File: rtl/wdt_fsel_chk.sv
module wdt_fsel_chk
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS_SHORT = 3,
  parameter int unsigned TICKS_LONG  = 50,
  localparam int unsigned TMAX = (TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT,
  localparam int unsigned PW   = (TMAX > 2) ? $clog2(TMAX) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         reg_addr,
  input logic               reg_wr,
  input logic [7:0]         reg_wdata,
  input logic               wd_expired,
  input logic [UNITS_W-1:0] units,
  input logic [PW-1:0]      presc,
  input logic               long_sel,
  input logic [FS_W-1:0]    strap_lat,
  input logic               strap_done
);
  logic clr_wr, ctrl_wr;
  assign clr_wr  = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expired && !clr_wr) |=> wd_expired);

  // R4
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_expired) |-> (units == '0));

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((units == '0) && !ctrl_wr) |=> (units == '0));

  // R6
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ((units == units_of($past(reg_wdata[5:1]))) && (presc == '0)));

  // R3
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(presc) < (long_sel ? TICKS_LONG : TICKS_SHORT)));

  // R8
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> (strap_done && $stable(strap_lat)));
endmodule

bind wdt_fsel_top wdt_fsel_chk #(.TICKS_SHORT(TICKS_SHORT), .TICKS_LONG(TICKS_LONG)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .wd_expired(wd_expired), .units(units_q),
  .presc(presc_cnt), .long_sel(ctrl.psel), .strap_lat(strap_lat),
  .strap_done(strap_done)
);

// File: tb/wdt_fsel_top_tb_top.sv
module wdt_fsel_top_tb_top;
  localparam int unsigned TS = 3;
  localparam int unsigned TL = 50;
  localparam int NV = 6;
  localparam logic [4:0] VEC_TO [NV] = '{5'd1, 5'd2, 5'd0, 5'd1, 5'd3, 5'd31};
  localparam logic       VEC_PS [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int         VEC_EXP[NV] = '{3, 6, 96, 50, 150, 93};

  logic       clk, rst_n, base_tick, reg_wr, wd_expired;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [4:0] strap_fs, freq_code;
  int checks = 0, errors = 0;

  wdt_fsel_top #(.TICKS_SHORT(TS), .TICKS_LONG(TL)) dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .strap_fs(strap_fs), .freq_code(freq_code), .wd_expired(wd_expired)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  // Control write, then flag clear; flag checked one tick early and on time.
  task automatic expire_run(input string req, input logic [4:0] to, input logic ps, input int cyc);
    wr(2'd0, {2'b00, to, ps});
    wr(2'd1, 8'h01);
    repeat (cyc - 2) @(posedge clk);
    @(negedge clk);
    chk({req, " early"}, 32'(wd_expired), 32'd0);
    @(posedge clk); @(negedge clk);
    chk({req, " on time"}, 32'(wd_expired), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; base_tick = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    strap_fs = 5'h15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1 reset values
    rd_chk("R1 ctrl", 2'd0, 8'h3E);
    rd_chk("R1 status", 2'd1, 8'h00);
    rd_chk("R1 sel", 2'd2, 8'h00);
    chk("R1 flag", 32'(wd_expired), 32'd0);
    // R8 strap capture, later changes ignored
    strap_fs = 5'h0A;
    @(posedge clk); @(negedge clk);
    rd_chk("R8 strap readback", 2'd3, 8'h15);
    chk("R8 freq after pin change", 32'(freq_code), 32'h15);
    wr(2'd3, 8'hFF);
    rd_chk("R8 strap after write", 2'd3, 8'h15);
    // R7 override mux
    wr(2'd2, 8'h07);
    chk("R7 strap path", 32'(freq_code), 32'h15);
    wr(2'd0, 8'h7E);
    chk("R7 software path", 32'(freq_code), 32'h07);
    wr(2'd0, 8'h3E);
    chk("R7 back to strap", 32'(freq_code), 32'h15);
    // R9 reserved bits
    wr(2'd2, 8'hFF);
    rd_chk("R9 sel reserved", 2'd2, 8'h1F);
    wr(2'd0, 8'hFF);
    rd_chk("R9 ctrl reserved", 2'd0, 8'h7F);
    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      expire_run($sformatf("R3 R2 vec%0d", i), VEC_TO[i], VEC_PS[i], VEC_EXP[i]);
      rd_chk("R4 status bit", 2'd1, 8'h01);
    end
    // R5 sticky and clear
    repeat (20) @(posedge clk); @(negedge clk);
    chk("R5 sticky", 32'(wd_expired), 32'd1);
    wr(2'd1, 8'hFE);
    chk("R5 write 0 keeps", 32'(wd_expired), 32'd1);
    wr(2'd1, 8'h01);
    chk("R5 write 1 clears", 32'(wd_expired), 32'd0);
    // R4 no wrap after expiry
    repeat (200) @(posedge clk); @(negedge clk);
    chk("R4 stays clear at zero", 32'(wd_expired), 32'd0);
    // R6 kick postpones expiry
    wr(2'd0, {2'b00, 5'd2, 1'b0});
    wr(2'd1, 8'h01);
    repeat (3) @(posedge clk); @(negedge clk);
    wr(2'd0, {2'b00, 5'd2, 1'b0});
    repeat (5) @(posedge clk); @(negedge clk);
    chk("R6 kick delays", 32'(wd_expired), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R6 expires after kick", 32'(wd_expired), 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule